// File: doc/BRIEF.md
# Command Sequence Decoder

This block sits between a host write port and the write engine of a page-programmed non-volatile memory. It watches every host write (address and data byte) and recognises a small set of fixed multi-byte unlock sequences. From them it derives the mode signals the write engine needs: a page-load window with a commit pulse when it times out, a one-cycle chip-erase start with a timed busy interval, a product-identification mode flag and a sticky write-protection flag.

When protection is set, a page load can only begin after the three-byte unlock. Once the window is open, every write is passed on as a data load until the host goes quiet for a programmable number of cycles. Writes that match no sequence are either dropped (protected) or passed on as loads (unprotected). The page buffer and the read path belong to other blocks.

Top module: `cmdseq_decoder`

## Requirements
- R1: During and right after reset, `prot_en` equals the parameter `PROT_RESET` (default 1), and `load_valid`, `load_open`, `page_commit`, `erase_start`, `erase_busy` and `id_mode` are all 0.
- R2: The writes {5555h,AAh}, {2AAAh,55h}, {5555h,A0h}, given as {address,data}, set `prot_en` and open the load window. `load_open` is 1 in the cycle after the third write.
- R3: While the window is open, every accepted write becomes a load. `load_valid` pulses in the following cycle with that write's full address on `load_addr` and its byte on `load_data`.
- R4: The window closes after `WINDOW_CYCLES` consecutive clock edges with no accepted write. In the cycle it closes, `page_commit` pulses for one cycle. A write on the final edge is loaded and restarts the count, with no commit.
- R5: With `prot_en` at 1 and the window closed, a write that is not part of a sequence produces no load and leaves the window closed.
- R6: With `prot_en` at 0 and the window closed, a write that does not start a sequence (anything other than AAh at 5555h) is loaded directly and opens the window.
- R7: A write that differs from the next expected sequence byte drops the partial sequence and is itself discarded. The following write is judged as a first byte.
- R8: The six writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 10h@5555h produce a one-cycle `erase_start` in the next cycle. `erase_busy` is 1 for exactly `ERASE_CYCLES` cycles, starting in that same cycle.
- R9: Every write that arrives while `erase_busy` is 1 is ignored. It produces no load and no start, and it changes no mode or sequence progress.
- R10: The six-byte erase sequence with a final byte of 60h (instead of 10h) sets `id_mode`. The writes AAh@5555h, 55h@2AAAh, F0h@5555h clear it.
- R11: Sequence addresses are matched on `wr_addr[14:0]` only; higher address bits are ignored.
- R12: Once `prot_en` is 1 it stays 1 until reset, so every later page load must be preceded by the unlock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | One host write cycle this clock |
| wr_addr | input | ADDR_W | Host write address |
| wr_data | input | 8 | Host write data byte |
| load_valid | output | 1 | Data load to the page buffer this cycle |
| load_addr | output | ADDR_W | Address of the load |
| load_data | output | 8 | Byte of the load |
| load_open | output | 1 | Page-load window is open |
| page_commit | output | 1 | Window timed out; programming may start |
| erase_start | output | 1 | One-cycle chip-erase start |
| erase_busy | output | 1 | Chip-erase interval in progress |
| prot_en | output | 1 | Write protection is set |
| id_mode | output | 1 | Product-identification mode is active |

## Verification
Two functions can act on the same clock edge. One is the window timer reaching its final count while a new write arrives; the other is the erase interval's last busy cycle meeting an incoming write. The bench places a load exactly `WINDOW_CYCLES-1` idle cycles after the previous one, so it lands on the expiry edge. The cycle-accurate model then requires a load with no commit and a window that stays open. Unlock and sequence bytes sent during the erase interval are judged against the model on every cycle, and the window must stay shut and no load may appear.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;

    localparam int CMD_AW = 15;

    localparam logic [CMD_AW-1:0] ADR_MAIN = 15'h5555;
    localparam logic [CMD_AW-1:0] ADR_ALT  = 15'h2AAA;

    localparam logic [7:0] D_LEAD   = 8'hAA;
    localparam logic [7:0] D_SECOND = 8'h55;
    localparam logic [7:0] D_UNLOCK = 8'hA0;
    localparam logic [7:0] D_EXTEND = 8'h80;
    localparam logic [7:0] D_IDEXIT = 8'hF0;
    localparam logic [7:0] D_ERASE  = 8'h10;
    localparam logic [7:0] D_IDENT  = 8'h60;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_GOT1,
        SQ_GOT2,
        SQ_GOT3,
        SQ_GOT4,
        SQ_GOT5
    } seq_state_e;

    typedef struct packed {
        logic unlock;
        logic erase;
        logic id_enter;
        logic id_exit;
        logic load;
    } seq_event_t;

    function automatic logic cmd_hit(
        input logic [CMD_AW-1:0] a,
        input logic [7:0]        d,
        input logic [CMD_AW-1:0] exp_a,
        input logic [7:0]        exp_d
    );
        return (a == exp_a) && (d == exp_d);
    endfunction

endpackage

// File: rtl/cmdseq_matcher.sv
module cmdseq_matcher
    import cmdseq_pkg::*;
#(
    parameter int   ADDR_W     = 17,
    parameter logic PROT_RESET = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              window_open,
    input  logic              erase_busy,
    output seq_event_t        ev,
    output logic              prot_en,
    output logic              id_mode
);

    seq_state_e        state_q, state_d;
    logic [CMD_AW-1:0] cmd_addr;
    logic              accept;

    assign cmd_addr = wr_addr[CMD_AW-1:0];
    assign accept   = wr_valid && !erase_busy;

    always_comb begin
        state_d = state_q;
        ev      = '0;
        if (accept) begin
            if (window_open) begin
                ev.load = 1'b1;
            end else begin
                unique case (state_q)
                    SQ_IDLE: begin
                        if (cmd_hit(cmd_addr, wr_data, ADR_MAIN, D_LEAD))
                            state_d = SQ_GOT1;
                        else if (!prot_en)
                            ev.load = 1'b1;
                    end
                    SQ_GOT1: state_d = cmd_hit(cmd_addr, wr_data, ADR_ALT, D_SECOND)
                                       ? SQ_GOT2 : SQ_IDLE;
                    SQ_GOT2: begin
                        state_d = SQ_IDLE;
                        if (cmd_addr == ADR_MAIN) begin
                            if (wr_data == D_UNLOCK)      ev.unlock  = 1'b1;
                            else if (wr_data == D_EXTEND) state_d    = SQ_GOT3;
                            else if (wr_data == D_IDEXIT) ev.id_exit = 1'b1;
                        end
                    end
                    SQ_GOT3: state_d = cmd_hit(cmd_addr, wr_data, ADR_MAIN, D_LEAD)
                                       ? SQ_GOT4 : SQ_IDLE;
                    SQ_GOT4: state_d = cmd_hit(cmd_addr, wr_data, ADR_ALT, D_SECOND)
                                       ? SQ_GOT5 : SQ_IDLE;
                    SQ_GOT5: begin
                        state_d = SQ_IDLE;
                        if (cmd_addr == ADR_MAIN) begin
                            if (wr_data == D_ERASE)      ev.erase    = 1'b1;
                            else if (wr_data == D_IDENT) ev.id_enter = 1'b1;
                        end
                    end
                    default: state_d = SQ_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SQ_IDLE;
            prot_en <= PROT_RESET;
            id_mode <= 1'b0;
        end else begin
            state_q <= state_d;
            if (ev.unlock)
                prot_en <= 1'b1;
            if (ev.id_enter)
                id_mode <= 1'b1;
            else if (ev.id_exit)
                id_mode <= 1'b0;
        end
    end

endmodule

// File: rtl/cmdseq_load_window.sv
module cmdseq_load_window #(
    parameter int ADDR_W        = 17,
    parameter int WINDOW_CYCLES = 60000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              open_req,
    input  logic              load_req,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              load_valid,
    output logic [ADDR_W-1:0] load_addr,
    output logic [7:0]        load_data,
    output logic              window_open,
    output logic              page_commit
);

    localparam int TW = $clog2(WINDOW_CYCLES + 1);

    logic [TW-1:0] quiet_left;

    always_ff @(posedge clk) begin
        if (rst) begin
            load_valid  <= 1'b0;
            load_addr   <= '0;
            load_data   <= '0;
            window_open <= 1'b0;
            page_commit <= 1'b0;
            quiet_left  <= '0;
        end else begin
            load_valid  <= load_req;
            page_commit <= 1'b0;
            if (load_req) begin
                load_addr <= wr_addr;
                load_data <= wr_data;
            end
            if (load_req || open_req) begin
                window_open <= 1'b1;
                quiet_left  <= TW'(WINDOW_CYCLES);
            end else if (window_open) begin
                if (quiet_left == TW'(1)) begin
                    window_open <= 1'b0;
                    page_commit <= 1'b1;
                    quiet_left  <= '0;
                end else begin
                    quiet_left <= quiet_left - TW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/cmdseq_erase_timer.sv
module cmdseq_erase_timer #(
    parameter int ERASE_CYCLES = 10000000
) (
    input  logic clk,
    input  logic rst,
    input  logic start_req,
    output logic erase_start,
    output logic erase_busy
);

    localparam int CW = $clog2(ERASE_CYCLES + 1);

    logic [CW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            erase_start <= 1'b0;
            remain      <= '0;
        end else begin
            erase_start <= start_req;
            if (start_req)
                remain <= CW'(ERASE_CYCLES);
            else if (remain != '0)
                remain <= remain - CW'(1);
        end
    end

    assign erase_busy = (remain != '0);

endmodule

// File: rtl/cmdseq_decoder.sv
module cmdseq_decoder
    import cmdseq_pkg::*;
#(
    parameter int   ADDR_W        = 17,
    parameter int   WINDOW_CYCLES = 60000,
    parameter int   ERASE_CYCLES  = 10000000,
    parameter logic PROT_RESET    = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              load_valid,
    output logic [ADDR_W-1:0] load_addr,
    output logic [7:0]        load_data,
    output logic              load_open,
    output logic              page_commit,
    output logic              erase_start,
    output logic              erase_busy,
    output logic              prot_en,
    output logic              id_mode
);

    seq_event_t ev;

    cmdseq_matcher #(
        .ADDR_W     (ADDR_W),
        .PROT_RESET (PROT_RESET)
    ) matcher_i (
        .clk         (clk),
        .rst         (rst),
        .wr_valid    (wr_valid),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .window_open (load_open),
        .erase_busy  (erase_busy),
        .ev          (ev),
        .prot_en     (prot_en),
        .id_mode     (id_mode)
    );

    cmdseq_load_window #(
        .ADDR_W        (ADDR_W),
        .WINDOW_CYCLES (WINDOW_CYCLES)
    ) window_i (
        .clk         (clk),
        .rst         (rst),
        .open_req    (ev.unlock),
        .load_req    (ev.load),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .load_valid  (load_valid),
        .load_addr   (load_addr),
        .load_data   (load_data),
        .window_open (load_open),
        .page_commit (page_commit)
    );

    cmdseq_erase_timer #(
        .ERASE_CYCLES (ERASE_CYCLES)
    ) erase_i (
        .clk         (clk),
        .rst         (rst),
        .start_req   (ev.erase),
        .erase_start (erase_start),
        .erase_busy  (erase_busy)
    );

endmodule

// File: rtl/cmdseq_decoder_chk.sv
module cmdseq_decoder_chk (
    input logic clk,
    input logic rst,
    input logic wr_valid,
    input logic load_valid,
    input logic load_open,
    input logic page_commit,
    input logic erase_start,
    input logic erase_busy,
    input logic prot_en,
    input logic id_mode
);

    assert_load_in_window_R3: assert property (@(posedge clk) disable iff (rst)
        load_valid |-> load_open);

    assert_commit_closes_R4: assert property (@(posedge clk) disable iff (rst)
        page_commit |-> (!load_open && $past(load_open)));

    assert_commit_no_load_R4: assert property (@(posedge clk) disable iff (rst)
        page_commit |-> !load_valid);

    assert_start_busy_R8: assert property (@(posedge clk) disable iff (rst)
        erase_start |-> erase_busy);

    assert_start_single_R8: assert property (@(posedge clk) disable iff (rst)
        erase_start |=> !erase_start);

    assert_busy_ignores_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && erase_busy) |=>
            (!load_valid && !erase_start && $stable(id_mode) && $stable(prot_en)));

    assert_prot_sticky_R12: assert property (@(posedge clk) disable iff (rst)
        $past(prot_en) |-> prot_en);

endmodule

bind cmdseq_decoder cmdseq_decoder_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .wr_valid    (wr_valid),
    .load_valid  (load_valid),
    .load_open   (load_open),
    .page_commit (page_commit),
    .erase_start (erase_start),
    .erase_busy  (erase_busy),
    .prot_en     (prot_en),
    .id_mode     (id_mode)
);

// File: tb/cmdseq_decoder_tb_top.sv
module cmdseq_ref_model #(
    parameter int ADDR_W = 17,
    parameter int WIN    = 16,
    parameter int ERS    = 40,
    parameter bit PROT0  = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        data,
    output logic              load_valid,
    output logic [ADDR_W-1:0] load_addr,
    output logic [7:0]        load_data,
    output logic              load_open,
    output logic              page_commit,
    output logic              erase_start,
    output logic              erase_busy,
    output logic              prot_en,
    output logic              id_mode
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [22:0] hist[$];
    int idle_edges = 0;
    int busy_left  = 0;

    function automatic logic [22:0] ref_byte(input int s, input int i);
        case (i)
            0, 3:    return {15'h5555, 8'hAA};
            1, 4:    return {15'h2AAA, 8'h55};
            2:       return {15'h5555, (s == 0) ? 8'hA0 : (s == 3) ? 8'hF0 : 8'h80};
            default: return {15'h5555, (s == 1) ? 8'h10 : 8'h60};
        endcase
    endfunction

    function automatic int ref_len(input int s);
        return (s == 1 || s == 2) ? 6 : 3;
    endfunction

    initial begin
        load_valid = 0; load_addr = '0; load_data = '0; load_open = 0;
        page_commit = 0; erase_start = 0; erase_busy = 0;
        prot_en = PROT0; id_mode = 0;
    end

    always @(posedge clk) begin
        if (rst) begin
            hist.delete();
            idle_edges = 0; busy_left = 0;
            load_valid = 0; load_addr = '0; load_data = '0; load_open = 0;
            page_commit = 0; erase_start = 0; erase_busy = 0;
            prot_en = PROT0; id_mode = 0;
        end else begin
            bit was_busy;
            load_valid = 0; page_commit = 0; erase_start = 0;
            was_busy = (busy_left > 0);
            if (busy_left > 0) busy_left--;
            if (wv && !was_busy) begin
                if (load_open) begin
                    load_valid = 1; load_addr = addr; load_data = data; idle_edges = 0;
                end else begin
                    bit was_empty;
                    bit any_prefix;
                    int full;
                    was_empty = (hist.size() == 0);
                    hist.push_back({addr[14:0], data});
                    any_prefix = 0;
                    full = -1;
                    for (int s = 0; s < 4; s++) begin
                        bit ok;
                        ok = (hist.size() <= ref_len(s));
                        for (int i = 0; i < hist.size(); i++)
                            if (ok && hist[i] != ref_byte(s, i)) ok = 0;
                        if (ok) begin
                            any_prefix = 1;
                            if (hist.size() == ref_len(s)) full = s;
                        end
                    end
                    if (!any_prefix) begin
                        hist.delete();
                        if (was_empty && !prot_en) begin
                            load_valid = 1; load_addr = addr; load_data = data;
                            load_open = 1; idle_edges = 0;
                        end
                    end else if (full >= 0) begin
                        hist.delete();
                        case (full)
                            0: begin prot_en = 1; load_open = 1; idle_edges = 0; end
                            1: begin erase_start = 1; busy_left = ERS; end
                            2: id_mode = 1;
                            default: id_mode = 0;
                        endcase
                    end
                end
            end else if (load_open) begin
                idle_edges++;
                if (idle_edges == WIN) begin
                    load_open = 0; page_commit = 1;
                end
            end
            erase_busy = (busy_left > 0);
        end
    end
endmodule

module cmdseq_decoder_tb_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int AW  = 17;
    localparam int WIN = 16;
    localparam int ERS = 40;
    localparam int WATCHDOG = 20000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wv = 1'b0;
    logic [AW-1:0] wa = '0;
    logic [7:0] wd = '0;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    // protected instance and its model
    logic i_lv, i_open, i_commit, i_es, i_busy, i_prot, i_id;
    logic [AW-1:0] i_la; logic [7:0] i_ld;
    logic m_lv, m_open, m_commit, m_es, m_busy, m_prot, m_id;
    logic [AW-1:0] m_la; logic [7:0] m_ld;
    // unprotected-at-reset instance and its model
    logic u_lv, u_open, u_commit, u_es, u_busy, u_prot, u_id;
    logic [AW-1:0] u_la; logic [7:0] u_ld;
    logic n_lv, n_open, n_commit, n_es, n_busy, n_prot, n_id;
    logic [AW-1:0] n_la; logic [7:0] n_ld;

    cmdseq_decoder #(.ADDR_W(AW), .WINDOW_CYCLES(WIN), .ERASE_CYCLES(ERS), .PROT_RESET(1'b1)) dut_i (
        .clk(clk), .rst(rst), .wr_valid(wv), .wr_addr(wa), .wr_data(wd),
        .load_valid(i_lv), .load_addr(i_la), .load_data(i_ld), .load_open(i_open),
        .page_commit(i_commit), .erase_start(i_es), .erase_busy(i_busy),
        .prot_en(i_prot), .id_mode(i_id));

    cmdseq_decoder #(.ADDR_W(AW), .WINDOW_CYCLES(WIN), .ERASE_CYCLES(ERS), .PROT_RESET(1'b0)) dut_u (
        .clk(clk), .rst(rst), .wr_valid(wv), .wr_addr(wa), .wr_data(wd),
        .load_valid(u_lv), .load_addr(u_la), .load_data(u_ld), .load_open(u_open),
        .page_commit(u_commit), .erase_start(u_es), .erase_busy(u_busy),
        .prot_en(u_prot), .id_mode(u_id));

    cmdseq_ref_model #(.ADDR_W(AW), .WIN(WIN), .ERS(ERS), .PROT0(1'b1)) ref_i (
        .clk(clk), .rst(rst), .wv(wv), .addr(wa), .data(wd),
        .load_valid(m_lv), .load_addr(m_la), .load_data(m_ld), .load_open(m_open),
        .page_commit(m_commit), .erase_start(m_es), .erase_busy(m_busy),
        .prot_en(m_prot), .id_mode(m_id));

    cmdseq_ref_model #(.ADDR_W(AW), .WIN(WIN), .ERS(ERS), .PROT0(1'b0)) ref_u (
        .clk(clk), .rst(rst), .wv(wv), .addr(wa), .data(wd),
        .load_valid(n_lv), .load_addr(n_la), .load_data(n_ld), .load_open(n_open),
        .page_commit(n_commit), .erase_start(n_es), .erase_busy(n_busy),
        .prot_en(n_prot), .id_mode(n_id));

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", tag, what, act, exp, cycles);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    // cycle-by-cycle comparison against the reference models
    always @(negedge clk) begin
        cycles++;
        if (!rst) begin
            chk("R3",  "i.load_valid", i_lv, m_lv);
            if (m_lv) begin
                chk("R3", "i.load_addr", i_la, m_la);
                chk("R3", "i.load_data", i_ld, m_ld);
            end
            chk("R2",  "i.load_open",   i_open,   m_open);
            chk("R4",  "i.page_commit", i_commit, m_commit);
            chk("R8",  "i.erase_start", i_es,     m_es);
            chk("R8",  "i.erase_busy",  i_busy,   m_busy);
            chk("R12", "i.prot_en",     i_prot,   m_prot);
            chk("R10", "i.id_mode",     i_id,     m_id);
            chk("R6",  "u.load_valid", u_lv, n_lv);
            if (n_lv) begin
                chk("R6", "u.load_addr", u_la, n_la);
                chk("R6", "u.load_data", u_ld, n_ld);
            end
            chk("R6",  "u.load_open",   u_open,   n_open);
            chk("R4",  "u.page_commit", u_commit, n_commit);
            chk("R8",  "u.erase_start", u_es,     n_es);
            chk("R8",  "u.erase_busy",  u_busy,   n_busy);
            chk("R12", "u.prot_en",     u_prot,   n_prot);
            chk("R10", "u.id_mode",     u_id,     n_id);
        end
        if (cycles >= WATCHDOG) begin
            n_fails++;
            $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WATCHDOG);
            finish_run();
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        wv = 1'b1; wa = a; wd = d;
        @(negedge clk);
        wv = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic erase_like(input logic [7:0] last);
        wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'h80);
        wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, last);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1", "i.prot_en", i_prot, 1);
        chk("R1", "u.prot_en", u_prot, 0);
        chk("R1", "i.load_open", i_open, 0);
        chk("R1", "i.erase_busy", i_busy, 0);
        chk("R1", "i.id_mode", i_id, 0);
        chk("R1", "u.load_valid", u_lv, 0);

        // R5 / R6: plain write with and without protection
        wr(17'h00123, 8'h5A);
        chk("R5", "i.load_valid", i_lv, 0);
        chk("R5", "i.load_open", i_open, 0);
        chk("R6", "u.load_valid", u_lv, 1);
        chk("R6", "u.load_data", u_ld, 8'h5A);
        chk("R6", "u.load_open", u_open, 1);
        idle(WIN + 2);

        // R7: broken sequence is dropped, next write judged afresh
        wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'h77);
        chk("R7", "i.load_valid", i_lv, 0);
        chk("R7", "u.load_valid", u_lv, 0);
        wr(17'h02AAA, 8'h55);
        chk("R7", "u.load_valid", u_lv, 1);
        chk("R7", "i.load_open", i_open, 0);
        idle(WIN + 2);

        // R2 / R11: unlock with high address bits set
        wr(17'h1D555, 8'hAA); wr(17'h0AAAA, 8'h55); wr(17'h15555, 8'hA0);
        chk("R11", "i.load_open", i_open, 1);
        chk("R2", "u.prot_en", u_prot, 1);
        chk("R2", "u.load_open", u_open, 1);
        // R3: loads in any order
        wr(17'h00400, 8'hC3);
        chk("R3", "i.load_valid", i_lv, 1);
        chk("R3", "i.load_addr", i_la, 17'h00400);
        chk("R3", "i.load_data", i_ld, 8'hC3);
        wr(17'h0047F, 8'h3C); wr(17'h00410, 8'h99);
        // R4: write landing on the expiry edge
        idle(WIN - 1);
        wr(17'h00420, 8'h5E);
        chk("R4", "i.load_valid", i_lv, 1);
        chk("R4", "i.page_commit", i_commit, 0);
        chk("R4", "i.load_open", i_open, 1);
        idle(WIN - 1);
        chk("R4", "i.load_open", i_open, 1);
        idle(1);
        chk("R4", "i.page_commit", i_commit, 1);
        chk("R4", "i.load_open", i_open, 0);

        // R12: protection stays on
        wr(17'h00200, 8'h11);
        chk("R12", "i.load_valid", i_lv, 0);
        chk("R12", "u.load_valid", u_lv, 0);
        chk("R12", "u.prot_en", u_prot, 1);

        // R8 / R9: chip erase and writes during busy
        erase_like(8'h10);
        chk("R8", "i.erase_start", i_es, 1);
        chk("R8", "i.erase_busy", i_busy, 1);
        wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'hA0);
        wr(17'h00300, 8'h22);
        chk("R9", "i.load_valid", i_lv, 0);
        chk("R9", "i.load_open", i_open, 0);
        idle(ERS - 5);
        chk("R8", "i.erase_busy", i_busy, 1);
        idle(1);
        chk("R8", "i.erase_busy", i_busy, 0);

        // R10: identification entry and exit
        erase_like(8'h60);
        chk("R10", "i.id_mode", i_id, 1);
        chk("R10", "i.erase_start", i_es, 0);
        wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'hF0);
        chk("R10", "i.id_mode", i_id, 0);

        // final page load
        wr(17'h05555, 8'hAA); wr(17'h02AAA, 8'h55); wr(17'h05555, 8'hA0);
        wr(17'h0057F, 8'h01); wr(17'h00500, 8'h02);
        idle(WIN + 3);
        finish_run();
    end
endmodule